// File: doc/BRIEF.md
# Three-Wire Serial Shutter Settings Receiver

This block takes electronic-shutter settings for a camera sensor timing core from one of two sources. In serial mode, a host drives three lines: a strobe, a bit clock and a data line. The block shifts in a 12-bit word one bit per bit-clock rising edge. When the strobe falls, it commits the word to an active settings register. In parallel mode, two mode pins and three speed-select pins are used directly. The downstream shutter controller uses the speed-select pins through its own lookup.

The three serial lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are detected on the synchronized copies. A word is committed only when at least 12 bits have arrived since the previous strobe. A shorter burst is discarded. After reset the register holds the "no shutter" setting. In serial mode the mode bits carried in the word decide the shutter mode, and the mode pins are ignored.

Top module: `shutter_serial_rx`

## Requirements
- R1: While and right after reset, `load_val` is 0x1FF. With `par_sel` low, `shut_mode` is 2'b11 (no shutter operation). The received-bit count restarts from zero.
- R2: With `par_sel` high (parallel), `shut_mode` equals `pin_mode` and `speed_sel` equals `pin_speed`, combinationally. With `par_sel` low (serial), `speed_sel` is 0.
- R3: `wire_dat` is taken at each synchronized rising edge of `wire_clk`. The first bit of a word lands in `load_val[0]`.
- R4: Bits are assigned in the order they are sent. Bits 1 to 9 become `load_val[0]` to `load_val[8]`. Bit 10 becomes `shut_mode[1]`, bit 11 becomes `shut_mode[0]`, and bit 12 is a dummy that is dropped.
- R5: On a synchronized falling edge of `wire_stb`, if at least 12 bits arrived since the previous falling edge, the last 12 bits become the active setting. The bit count then restarts from zero.
- R6: A strobe falling edge with fewer than 12 bits since the previous one leaves `load_val` and the serial mode unchanged. It still restarts the bit count.
- R7: When more than 12 bits arrive before a strobe, only the 12 most recent bits are used.
- R8: With `par_sel` low, changes on `pin_mode` have no effect on `shut_mode`, which shows the committed serial mode bits.
- R9: When a bit-clock rising edge and a strobe falling edge are detected in the same system cycle, the new bit is shifted in and counted first. It is part of the committed word.
- R10: An edge on `wire_clk` or `wire_stb` first seen by the system clock at rising edge n takes effect on the outputs at rising edge n+2.
- R11: Frames received while `par_sel` is high still update the active register. That value appears on `shut_mode` once `par_sel` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_sel | input | 1 | 1: parallel pin settings, 0: serial settings |
| wire_stb | input | 1 | Serial strobe, asynchronous, idles high |
| wire_clk | input | 1 | Serial bit clock, asynchronous |
| wire_dat | input | 1 | Serial data, asynchronous |
| pin_mode | input | 2 | Parallel shutter mode pins |
| pin_speed | input | 3 | Parallel speed-select pins |
| load_val | output | 9 | Committed 9-bit shutter load value |
| shut_mode | output | 2 | Effective shutter mode |
| speed_sel | output | 3 | Speed-select code in parallel mode, else 0 |

## Verification
Two functions can fall in the same system cycle:
- the shifting of the final bit of a word, and
- the commit triggered by the strobe's falling edge.

The bench provokes this by raising the bit clock and dropping the strobe on the same system-clock edge, so both synchronized edges appear together. It judges the result by whether the committed load value and mode include that last bit (R9). A behavioural model with its own input history is compared with every output on every cycle, so the collision, short bursts and over-long bursts are all judged at the exact cycle they take effect.

// File: rtl/shsr_pkg.sv
`timescale 1ns/1ps
package shsr_pkg;
    localparam int LOAD_W    = 9;
    localparam int MODE_W    = 2;
    localparam int SPEED_W   = 3;
    localparam int PAYLOAD_W = LOAD_W + MODE_W;
    localparam int FRAME_W   = PAYLOAD_W + 1;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [LOAD_W-1:0] load;
    } shut_cfg_t;

    typedef struct packed {
        logic stb;
        logic bclk;
        logic dat;
    } wire_bus_t;

    localparam shut_cfg_t CFG_RESET = '{mode: '1, load: '1};

    // Payload is bit-serial LSB first: load bits, then the first mode bit
    // (mode MSB), then the second mode bit (mode LSB).
    function automatic shut_cfg_t payload_to_cfg(input logic [PAYLOAD_W-1:0] p);
        shut_cfg_t c;
        c.load = p[LOAD_W-1:0];
        for (int i = 0; i < MODE_W; i++) begin
            c.mode[MODE_W-1-i] = p[LOAD_W+i];
        end
        return c;
    endfunction
endpackage

// File: rtl/wire_sync.sv
`timescale 1ns/1ps
module wire_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
`timescale 1ns/1ps
module frame_shifter
    import shsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_rise,
    input  logic                 bit_val,
    input  logic                 frame_end,
    output logic [PAYLOAD_W-1:0] payload_next,
    output logic                 full_next
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] sr_q, sr_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;

    always_comb begin
        sr_d  = bit_rise ? {bit_val, sr_q[FRAME_W-1:1]} : sr_q;
        cnt_d = (bit_rise && cnt_q != CNT_FULL) ? cnt_q + 1'b1 : cnt_q;
    end

    assign payload_next = sr_d[PAYLOAD_W-1:0];
    assign full_next    = (cnt_d == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else begin
            sr_q  <= sr_d;
            cnt_q <= frame_end ? '0 : cnt_d;
        end
    end

    // R7: count saturates at one frame, never beyond
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);

    // R5: the strobe restarts the bit count
    assert_count_restart_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> cnt_q == '0);
endmodule

// File: rtl/cfg_latch.sv
`timescale 1ns/1ps
module cfg_latch
    import shsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_end,
    input  logic                 full_next,
    input  logic [PAYLOAD_W-1:0] payload_next,
    output shut_cfg_t            active
);
    always_ff @(posedge clk) begin
        if (rst)                         active <= CFG_RESET;
        else if (frame_end && full_next) active <= payload_to_cfg(payload_next);
    end

    // R6: a short burst leaves the active setting alone
    assert_short_frame_held_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !full_next) |=> $stable(active));

    // R5: a full frame is committed at the strobe
    assert_frame_commit_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_end && full_next) |=> active == payload_to_cfg($past(payload_next)));

    // no change without a strobe
    assert_hold_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(active));
endmodule

// File: rtl/shutter_serial_rx.sv
`timescale 1ns/1ps
module shutter_serial_rx
    import shsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               par_sel,
    input  logic               wire_stb,
    input  logic               wire_clk,
    input  logic               wire_dat,
    input  logic [MODE_W-1:0]  pin_mode,
    input  logic [SPEED_W-1:0] pin_speed,
    output logic [LOAD_W-1:0]  load_val,
    output logic [MODE_W-1:0]  shut_mode,
    output logic [SPEED_W-1:0] speed_sel
);
    localparam wire_bus_t IDLE_BUS = '{stb: 1'b1, bclk: 1'b1, dat: 1'b0};

    wire_bus_t sbus;
    logic      stb_d, bclk_d;
    logic      bit_rise, frame_end, full_next;
    logic [PAYLOAD_W-1:0] payload_next;
    shut_cfg_t active;

    wire_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   ($bits(wire_bus_t)),
        .RST_VAL (IDLE_BUS)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({wire_stb, wire_clk, wire_dat}),
        .q   (sbus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_d  <= IDLE_BUS.stb;
            bclk_d <= IDLE_BUS.bclk;
        end else begin
            stb_d  <= sbus.stb;
            bclk_d <= sbus.bclk;
        end
    end

    assign bit_rise  = sbus.bclk & ~bclk_d;
    assign frame_end = ~sbus.stb & stb_d;

    frame_shifter u_shift (
        .clk          (clk),
        .rst          (rst),
        .bit_rise     (bit_rise),
        .bit_val      (sbus.dat),
        .frame_end    (frame_end),
        .payload_next (payload_next),
        .full_next    (full_next)
    );

    cfg_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .frame_end    (frame_end),
        .full_next    (full_next),
        .payload_next (payload_next),
        .active       (active)
    );

    always_comb begin
        load_val  = active.load;
        shut_mode = par_sel ? pin_mode  : active.mode;
        speed_sel = par_sel ? pin_speed : '0;
    end

    // R1: reset value visible right after reset
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (load_val == '1 && (par_sel || shut_mode == '1)));

    // R8: mode pins have no effect in serial mode
    assert_pins_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (!par_sel && $past(!par_sel) && !$past(frame_end)) |-> $stable(shut_mode));
endmodule

// File: tb/sim_shutter_serial_rx.sv
`timescale 1ns/1ps
module sim_shutter_serial_rx;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_sel = 1'b0;
    logic       wire_stb = 1'b1;
    logic       wire_clk = 1'b0;
    logic       wire_dat = 1'b0;
    logic [1:0] pin_mode = 2'b00;
    logic [2:0] pin_speed = 3'b000;
    logic [8:0] load_val;
    logic [1:0] shut_mode;
    logic [2:0] speed_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PER/2) clk = ~clk;

    shutter_serial_rx u0 (
        .clk(clk), .rst(rst), .par_sel(par_sel),
        .wire_stb(wire_stb), .wire_clk(wire_clk), .wire_dat(wire_dat),
        .pin_mode(pin_mode), .pin_speed(pin_speed),
        .load_val(load_val), .shut_mode(shut_mode), .speed_sel(speed_sel)
    );

    // behavioural reference: input history, edges seen two samples late
    logic [2:0]  hist[$];
    logic [2:0]  cur, prv;
    logic [11:0] m_sr;
    int          m_cnt;
    logic [8:0]  m_load;
    logic [1:0]  m_mode;

    always @(posedge clk) begin
        if (rst) begin
            hist = {3'b110, 3'b110, 3'b110};
            m_sr = '0; m_cnt = 0; m_load = 9'h1FF; m_mode = 2'b11;
        end else begin
            hist.push_back({wire_stb, wire_clk, wire_dat});
            if (hist.size() > 8) void'(hist.pop_front());
            cur = hist[hist.size()-3];
            prv = hist[hist.size()-4];
            if (cur[1] && !prv[1]) begin
                m_sr = {cur[0], m_sr[11:1]};
                if (m_cnt < 12) m_cnt++;
            end
            if (!cur[2] && prv[2]) begin
                if (m_cnt == 12) begin
                    m_load = m_sr[8:0];
                    m_mode = {m_sr[9], m_sr[10]};
                end
                m_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R10: every-cycle comparison with the model, away from the edge
    always @(posedge clk) begin
        #(PER/4);
        if (!done) begin
            chk("R10 load_val", load_val, m_load);
            chk("R10 shut_mode", shut_mode, par_sel ? pin_mode : m_mode);
            chk("R10 speed_sel", speed_sel, par_sel ? pin_speed : 3'd0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        wire_dat = b;  wait_cyc(2);
        wire_clk = 1'b1; wait_cyc(3);
        wire_clk = 1'b0; wait_cyc(2);
    endtask

    task automatic strobe_pulse();
        wire_stb = 1'b0; wait_cyc(4);
        wire_stb = 1'b1; wait_cyc(6);
    endtask

    task automatic send_frame(input int n, input logic [31:0] bits);
        for (int i = 0; i < n; i++) send_bit(bits[i]);
        strobe_pulse();
    endtask

    initial begin
        #(PER * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(4);
        chk("R1 load during reset", load_val, 9'h1FF);
        chk("R1 mode during reset", shut_mode, 2'b11);
        rst = 1'b0;
        wait_cyc(3);
        chk("R1 load after reset", load_val, 9'h1FF);
        chk("R1 mode after reset", shut_mode, 2'b11);

        // R2: parallel pass-through
        par_sel = 1'b1;
        for (int k = 0; k < 8; k++) begin
            pin_mode = 2'(k); pin_speed = 3'(7 - k);
            #1;
            chk("R2 mode pins", shut_mode, k % 4);
            chk("R2 speed pins", speed_sel, 7 - k);
            wait_cyc(1);
        end
        par_sel = 1'b0; #1;
        chk("R2 speed zero in serial", speed_sel, 0);
        wait_cyc(2);

        // R3/R4/R5: full frame, load 0x0FA, mode 01
        send_frame(12, 32'hCFA);
        chk("R3 R4 load", load_val, 9'h0FA);
        chk("R4 mode", shut_mode, 2'b01);

        // R8: pins ignored in serial mode
        for (int k = 0; k < 4; k++) begin
            pin_mode = 2'(k); wait_cyc(2);
            chk("R8 pins ignored", shut_mode, 2'b01);
        end

        // R6: short burst ignored
        send_frame(7, 32'h55);
        chk("R6 load held", load_val, 9'h0FA);
        chk("R6 mode held", shut_mode, 2'b01);

        // R7: 15 bits, last 12 give load 0x196 mode 00
        send_frame(15, 32'hCB5);
        chk("R7 load last bits", load_val, 9'h196);
        chk("R7 mode last bits", shut_mode, 2'b00);

        // R9: final bit edge and strobe fall together, load 0x137 mode 10
        for (int i = 0; i < 11; i++) send_bit(12'h337 >> i);
        wire_dat = 1'b0; wait_cyc(2);
        wire_clk = 1'b1; wire_stb = 1'b0; wait_cyc(4);
        wire_clk = 1'b0; wire_stb = 1'b1; wait_cyc(6);
        chk("R9 collision load", load_val, 9'h137);
        chk("R9 collision mode", shut_mode, 2'b10);

        // R11: frame during parallel mode, load 0x1FE mode 11
        par_sel = 1'b1; pin_mode = 2'b00;
        send_frame(12, 32'h7FE);
        chk("R11 load updated", load_val, 9'h1FE);
        chk("R11 pins shown", shut_mode, 2'b00);
        par_sel = 1'b0; #1;
        chk("R11 serial mode shown", shut_mode, 2'b11);

        // R1: reset mid-run restores default
        wait_cyc(1);
        rst = 1'b1; wait_cyc(2); rst = 1'b0; wait_cyc(1);
        chk("R1 reset restores load", load_val, 9'h1FF);
        chk("R1 reset restores mode", shut_mode, 2'b11);

        wait_cyc(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule